// File: doc/BRIEF.md
# Register-Register Integer Add Execute Unit

This block executes one three-register integer add. It decodes a 32-bit instruction word, presents the two source register indices to an external register file, takes the two 64-bit operand values returned in the same cycle, and one clock later writes the 64-bit sum back to the destination index. The carry-out of the addition is dropped and never kept.

Two optional side effects are selected by flag bits in the word. When the overflow-enable flag is set, the unit records signed overflow in an overflow flag and ORs it into a sticky summary-overflow flag. Only the external clear input resets the summary flag. When the record flag is set, the unit writes a 4-bit condition field from a signed comparison of the result against zero. A parameter sets whether that comparison uses the whole 64-bit result or only its low 32 bits taken as signed. Overflow only sets the flags. It never raises a trap.

A small state machine tracks what the previous cycle accepted:
- `ST_IDLE`: no instruction was taken.
- `ST_COMMIT`: a legal add was taken, so the writeback strobe is high.
- `ST_REJECT`: an illegal word was taken, so the illegal strobe is high.

From every state the machine moves on each clock:
- to `ST_COMMIT` when the valid input is high and the word is legal;
- to `ST_REJECT` when the valid input is high and the word is not legal;
- to `ST_IDLE` when the valid input is low.

Top module: `add_exec_unit`

## Requirements
- R1: Bit 31 of `instr_word` is the most significant bit. A word is legal only when `instr_word[31:26]` equals 31 and `instr_word[9:1]` equals 266. The destination index is `[25:21]`, source A is `[20:16]` and source B is `[15:11]`. `src_a_idx` and `src_b_idx` show the source fields of the current word combinationally.
- R2: On the clock edge after a valid legal word, `wb_en` is 1 for one cycle, `wb_idx` holds the destination field and `wb_data` holds `src_a_val + src_b_val` modulo 2^64.
- R3: Signed overflow is 1 exactly when both operands have the same bit 63 and bit 63 of the sum differs from it.
- R4: When the overflow-enable bit `instr_word[10]` is 1, `xer_ov` takes the overflow value (0 or 1) on the commit edge. `xer_so` becomes its old value OR that overflow value.
- R5: When `instr_word[10]` is 0, neither `xer_ov` nor `xer_so` is changed by the add.
- R6: `xer_so` stays set until `so_clear` is applied, and `so_clear` does not change `xer_ov`. When `so_clear` and an overflowing add with overflow-enable arrive in the same cycle, `xer_so` ends up 1.
- R7: When the record bit `instr_word[0]` is 1, `cr0` is written as {LT, GT, EQ, SO} in bits 3..0. Exactly one of LT, GT and EQ is set, from a signed comparison of the result with zero. SO equals `xer_so` after this instruction's own update.
- R8: When `instr_word[0]` is 0, `cr0` is unchanged.
- R9: A valid word that is not legal gives `illegal` = 1 for one cycle on the next edge. It gives no writeback and changes neither the flags nor `cr0`.
- R10: With `CMP_W` = 64 the compare uses all 64 bits of the result. With `CMP_W` = 32 it uses the low 32 bits as a signed value.
- R11: The destination and both source indices may be equal. The operands are sampled before the writeback.
- R12: After reset, `wb_en`, `illegal`, `xer_ov`, `xer_so` and `cr0` are all 0.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr_word | input | 32 | Instruction word |
| src_a_idx | output | 5 | Register index of source A |
| src_b_idx | output | 5 | Register index of source B |
| src_a_val | input | 64 | Source A value from the register file |
| src_b_val | input | 64 | Source B value from the register file |
| so_clear | input | 1 | Request to clear the sticky summary flag |
| wb_en | output | 1 | Writeback strobe |
| wb_idx | output | 5 | Writeback destination index |
| wb_data | output | 64 | Writeback value |
| illegal | output | 1 | Strobe for a rejected word |
| xer_ov | output | 1 | Overflow flag |
| xer_so | output | 1 | Sticky summary-overflow flag |
| cr0 | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
The source index outputs are combinational, so the bench reads them in the same cycle it presents the word. Every other result is due exactly one clock edge after the valid cycle: writeback, illegal strobe, both flags and the condition field. A clear request applied alone also takes effect on that next edge. The bench drives on the falling edge and reads back on the following falling edge, after the single committing rising edge. A second instance with the narrow compare width receives the same stimulus, so its condition field can be compared against the wide one for values that differ only above bit 31.

// File: rtl/add_exec_pkg.sv
`timescale 1ns/1ps
package add_exec_pkg;

    localparam int unsigned INSN_W     = 32;
    localparam int unsigned RIDX_W     = 5;
    localparam logic [5:0]  PRIMARY_OP = 6'd31;
    localparam logic [8:0]  EXT_OP     = 9'd266;

    // Condition field bit positions
    localparam int unsigned CF_LT = 3;
    localparam int unsigned CF_GT = 2;
    localparam int unsigned CF_EQ = 1;
    localparam int unsigned CF_SO = 0;

    // Field order follows the word from most to least significant bit
    typedef struct packed {
        logic [5:0]        prim;
        logic [RIDX_W-1:0] dst;
        logic [RIDX_W-1:0] srca;
        logic [RIDX_W-1:0] srcb;
        logic              ovf_en;
        logic [8:0]        ext;
        logic              rec;
    } add_insn_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COMMIT,
        ST_REJECT
    } xu_state_e;

endpackage

// File: rtl/add_exec_decode.sv
`timescale 1ns/1ps
module add_exec_decode
    import add_exec_pkg::*;
(
    input  logic [INSN_W-1:0] word,
    output logic [RIDX_W-1:0] dst,
    output logic [RIDX_W-1:0] srca,
    output logic [RIDX_W-1:0] srcb,
    output logic              ovf_en,
    output logic              rec,
    output logic              legal
);
    add_insn_t f;

    always_comb begin
        f      = add_insn_t'(word);
        dst    = f.dst;
        srca   = f.srca;
        srcb   = f.srcb;
        ovf_en = f.ovf_en;
        rec    = f.rec;
        legal  = (f.prim == PRIMARY_OP) && (f.ext == EXT_OP);
    end
endmodule

// File: rtl/add_exec_sum.sv
`timescale 1ns/1ps
module add_exec_sum #(
    parameter int unsigned XLEN = 64
) (
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    output logic [XLEN-1:0] sum,
    output logic            sgn_ovf
);
    localparam int unsigned MSB = XLEN - 1;

    always_comb begin
        sum     = op_a + op_b;              // carry-out is dropped
        sgn_ovf = (op_a[MSB] == op_b[MSB]) && (sum[MSB] != op_a[MSB]);
    end
endmodule

// File: rtl/add_exec_cmp.sv
`timescale 1ns/1ps
module add_exec_cmp #(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0] value,
    output logic         lt,
    output logic         gt,
    output logic         eq
);
    always_comb begin
        lt = value[W-1];
        eq = (value == '0);
        gt = !lt && !eq;
    end
endmodule

// File: rtl/add_exec_unit.sv
`timescale 1ns/1ps
module add_exec_unit
    import add_exec_pkg::*;
#(
    parameter int unsigned XLEN  = 64,
    parameter int unsigned CMP_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [31:0]       instr_word,
    output logic [4:0]        src_a_idx,
    output logic [4:0]        src_b_idx,
    input  logic [XLEN-1:0]   src_a_val,
    input  logic [XLEN-1:0]   src_b_val,
    input  logic              so_clear,
    output logic              wb_en,
    output logic [4:0]        wb_idx,
    output logic [XLEN-1:0]   wb_data,
    output logic              illegal,
    output logic              xer_ov,
    output logic              xer_so,
    output logic [3:0]        cr0
);
    logic [RIDX_W-1:0] dst_f;
    logic              ovf_en, rec, legal;
    logic [XLEN-1:0]   sum;
    logic              sgn_ovf;
    logic              c_lt, c_gt, c_eq;

    add_exec_decode u_dec (
        .word   (instr_word),
        .dst    (dst_f),
        .srca   (src_a_idx),
        .srcb   (src_b_idx),
        .ovf_en (ovf_en),
        .rec    (rec),
        .legal  (legal)
    );

    add_exec_sum #(.XLEN(XLEN)) u_sum (
        .op_a    (src_a_val),
        .op_b    (src_b_val),
        .sum     (sum),
        .sgn_ovf (sgn_ovf)
    );

    generate
        if (CMP_W < XLEN) begin : g_narrow_cmp
            add_exec_cmp #(.W(CMP_W)) u_cmp (
                .value (sum[CMP_W-1:0]),
                .lt    (c_lt),
                .gt    (c_gt),
                .eq    (c_eq)
            );
        end else begin : g_full_cmp
            add_exec_cmp #(.W(XLEN)) u_cmp (
                .value (sum),
                .lt    (c_lt),
                .gt    (c_gt),
                .eq    (c_eq)
            );
        end
    endgenerate

    // ---------------- state machine ----------------
    xu_state_e state, state_nx;

    always_comb begin
        state_nx = ST_IDLE;
        if (instr_valid) begin
            state_nx = legal ? ST_COMMIT : ST_REJECT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        wb_en   = 1'b0;
        illegal = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_COMMIT: wb_en   = 1'b1;
            ST_REJECT: illegal = 1'b1;
            default:   ;
        endcase
    end

    // ---------------- result and flag registers ----------------
    logic fire, ov_nx, so_nx;
    logic [3:0] cr_nx;

    always_comb begin
        fire  = instr_valid && legal;
        ov_nx = (fire && ovf_en) ? sgn_ovf : xer_ov;
        so_nx = (xer_so && !so_clear) || (fire && ovf_en && sgn_ovf);
        cr_nx = cr0;
        if (fire && rec) begin
            cr_nx[CF_LT] = c_lt;
            cr_nx[CF_GT] = c_gt;
            cr_nx[CF_EQ] = c_eq;
            cr_nx[CF_SO] = so_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wb_idx  <= '0;
            wb_data <= '0;
            xer_ov  <= 1'b0;
            xer_so  <= 1'b0;
            cr0     <= '0;
        end else begin
            if (fire) begin
                wb_idx  <= dst_f;
                wb_data <= sum;
            end
            xer_ov <= ov_nx;
            xer_so <= so_nx;
            cr0    <= cr_nx;
        end
    end
endmodule

// File: rtl/add_exec_checks.sv
`timescale 1ns/1ps
module add_exec_checks
    import add_exec_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            instr_valid,
    input logic [31:0]     instr_word,
    input logic [XLEN-1:0] src_a_val,
    input logic [XLEN-1:0] src_b_val,
    input logic            so_clear,
    input logic            wb_en,
    input logic [XLEN-1:0] wb_data,
    input logic            illegal,
    input logic            xer_ov,
    input logic            xer_so,
    input logic [3:0]      cr0
);
    add_insn_t w;
    logic      ok_word;
    always_comb begin
        w       = add_insn_t'(instr_word);
        ok_word = (w.prim == PRIMARY_OP) && (w.ext == EXT_OP);
    end

    p_wb_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> $past(instr_valid));

    p_wb_sum_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (wb_data == $past(src_a_val) + $past(src_b_val)));

    p_ov_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(instr_valid && ok_word && w.ovf_en) |=> $stable(xer_ov));

    p_so_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (xer_so && !so_clear) |=> xer_so);

    p_ov_sets_so_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xer_ov) |-> xer_so);

    p_cmp_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cr0[3:1]));

    p_reject_r9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!wb_en && $stable(xer_ov) && $stable(cr0)));
endmodule

bind add_exec_unit add_exec_checks #(.XLEN(XLEN)) u_chk (.*);

// File: tb/add_exec_unit_bench.sv
`timescale 1ns/1ps
module add_exec_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_word = '0;
    logic [63:0] src_a_val = '0, src_b_val = '0;
    logic        so_clear = 1'b0;

    logic [4:0]  src_a_idx, src_b_idx, wb_idx, n_a_idx, n_b_idx, n_wb_idx;
    logic        wb_en, illegal, xer_ov, xer_so;
    logic        n_wb_en, n_illegal, n_ov, n_so;
    logic [63:0] wb_data, n_wb_data;
    logic [3:0]  cr0, n_cr0;

    int n_tests = 0;
    int n_fail  = 0;

    // model state
    logic       m_ov = 0, m_so = 0;
    logic [3:0] m_cr = 0, m_cr_n = 0;

    always #2 clk = ~clk;   // 250 MHz

    add_exec_unit u_add_exec_unit (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
        .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
        .src_a_val(src_a_val), .src_b_val(src_b_val), .so_clear(so_clear),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data), .illegal(illegal),
        .xer_ov(xer_ov), .xer_so(xer_so), .cr0(cr0));

    add_exec_unit #(.CMP_W(32)) u_narrow (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
        .src_a_idx(n_a_idx), .src_b_idx(n_b_idx),
        .src_a_val(src_a_val), .src_b_val(src_b_val), .so_clear(so_clear),
        .wb_en(n_wb_en), .wb_idx(n_wb_idx), .wb_data(n_wb_data), .illegal(n_illegal),
        .xer_ov(n_ov), .xer_so(n_so), .cr0(n_cr0));

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [4:0] rt, ra, rb, input logic oe, rc);
        return {6'd31, rt, ra, rb, oe, 9'd266, rc};
    endfunction

    function automatic logic [3:0] cmp_of(input logic [63:0] v, input bit narrow, input logic so);
        logic lt, eq;
        lt = narrow ? v[31] : v[63];
        eq = narrow ? (v[31:0] == 0) : (v == 0);
        return {lt, !lt && !eq, eq, so};
    endfunction

    task automatic check_flags(input string req);
        check(xer_ov == m_ov, {req, " ov"}, 64'(xer_ov), 64'(m_ov));
        check(xer_so == m_so, {req, " so"}, 64'(xer_so), 64'(m_so));
        check(cr0 == m_cr, {req, " cr0"}, 64'(cr0), 64'(m_cr));
        check(n_cr0 == m_cr_n, {req, " R10 narrow cr0"}, 64'(n_cr0), 64'(m_cr_n));
    endtask

    task automatic run_add(input logic [4:0] rt, ra, rb, input logic oe, rc,
                           input logic [63:0] a, b, input logic clr);
        logic [63:0] s;
        logic        ov;
        @(negedge clk);
        instr_valid = 1; instr_word = mk(rt, ra, rb, oe, rc);
        src_a_val = a; src_b_val = b; so_clear = clr;
        #1;
        check(src_a_idx == ra, "R1 src_a_idx", 64'(src_a_idx), 64'(ra));
        check(src_b_idx == rb, "R1 src_b_idx", 64'(src_b_idx), 64'(rb));
        s  = a + b;
        ov = (a[63] == b[63]) && (s[63] != a[63]);
        if (oe) m_ov = ov;
        m_so = (m_so && !clr) || (oe && ov);
        if (rc) begin
            m_cr   = cmp_of(s, 0, m_so);
            m_cr_n = cmp_of(s, 1, m_so);
        end
        @(negedge clk);
        instr_valid = 0; so_clear = 0;
        check(wb_en == 1'b1, "R2 wb_en", 64'(wb_en), 64'd1);
        check(wb_idx == rt, "R2 wb_idx", 64'(wb_idx), 64'(rt));
        check(wb_data == s, "R2 wb_data", wb_data, s);
        check(illegal == 1'b0, "R9 illegal low on legal", 64'(illegal), 64'd0);
        check_flags(oe ? (rc ? "R3/R4/R7" : "R3/R4/R8") : (rc ? "R5/R7" : "R5/R8"));
    endtask

    task automatic t_reset;
        check(wb_en == 0, "R12 wb_en", 64'(wb_en), 0);
        check(illegal == 0, "R12 illegal", 64'(illegal), 0);
        check_flags("R12");
    endtask

    task automatic t_plain;
        run_add(5'd4, 5'd7, 5'd9, 0, 0, 64'd5, 64'd7, 0);
        @(negedge clk);
        check(wb_en == 0, "R2 single-cycle strobe", 64'(wb_en), 0);
    endtask

    task automatic t_wrap;   // unsigned wrap, no signed overflow, EQ
        run_add(5'd1, 5'd2, 5'd3, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0);
    endtask

    task automatic t_pos_overflow;
        run_add(5'd8, 5'd8, 5'd9, 1, 1, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 0);
        check(cr0 == 4'b1001, "R7 LT with SO", 64'(cr0), 64'h9);
    endtask

    task automatic t_oe_off_overflow;   // overflow with OE=0 leaves flags
        run_add(5'd10, 5'd11, 5'd12, 0, 0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 0);
    endtask

    task automatic t_sticky;   // OE=1 no overflow: ov clears, so stays
        run_add(5'd13, 5'd14, 5'd15, 1, 1, 64'd3, 64'd4, 0);
        check(xer_so == 1, "R6 so sticky", 64'(xer_so), 1);
        check(cr0 == 4'b0101, "R7 GT with SO", 64'(cr0), 64'h5);
    endtask

    task automatic t_clear_alone;
        @(negedge clk);
        so_clear = 1;
        m_so = 0;
        @(negedge clk);
        so_clear = 0;
        check(xer_so == 0, "R6 clear", 64'(xer_so), 0);
        check(xer_ov == m_ov, "R6 clear keeps ov", 64'(xer_ov), 64'(m_ov));
    endtask

    task automatic t_clear_vs_set;   // negative overflow with clear: set wins
        run_add(5'd20, 5'd21, 5'd22, 1, 0, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1);
        check(xer_so == 1, "R6 set beats clear", 64'(xer_so), 1);
    endtask

    task automatic t_illegal(input logic [31:0] word);
        @(negedge clk);
        instr_valid = 1; instr_word = word;
        src_a_val = 64'h7FFF_FFFF_FFFF_FFFF; src_b_val = 64'd1;
        @(negedge clk);
        instr_valid = 0;
        check(illegal == 1, "R9 illegal", 64'(illegal), 1);
        check(wb_en == 0, "R9 no writeback", 64'(wb_en), 0);
        check_flags("R9");
    endtask

    task automatic t_alias;
        run_add(5'd3, 5'd3, 5'd3, 0, 1, 64'd21, 64'd21, 0);
        check(wb_data == 64'd42 && wb_idx == 5'd3, "R11 aliased", wb_data, 64'd42);
    endtask

    task automatic t_width;
        run_add(5'd5, 5'd6, 5'd7, 0, 1, 64'h0000_0000_8000_0000, 64'd0, 0);
        check(cr0[3:1] == 3'b010 && n_cr0[3:1] == 3'b100, "R10 bit31 set",
              64'({cr0, n_cr0}), 64'h0);
        run_add(5'd5, 5'd6, 5'd7, 0, 1, 64'h0000_0001_0000_0000, 64'd0, 0);
        check(cr0[3:1] == 3'b010 && n_cr0[3:1] == 3'b001, "R10 upper only",
              64'({cr0, n_cr0}), 64'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        t_plain();
        t_wrap();
        t_pos_overflow();
        t_oe_off_overflow();
        t_sticky();
        t_clear_alone();
        t_clear_vs_set();
        t_illegal({6'd30, 5'd1, 5'd2, 5'd3, 1'b1, 9'd266, 1'b1});
        t_illegal({6'd31, 5'd1, 5'd2, 5'd3, 1'b1, 9'd40, 1'b1});
        t_alias();
        t_width();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule